// File: doc/BRIEF.md
# Timestamp Capture and Event Interrupt Unit

This unit sits beside a free-running 64-bit time counter. It records the counter value when either of two external trigger pins rises, and it gathers four timer events into one sticky status register. The events are the two trigger captures, an alarm strobe and a pulse-per-second strobe. A per-event enable mask selects which status bits can raise the single level-sensitive interrupt line.

Software reaches the unit through a simple word-wide read and write port. Status bits are cleared by writing ones to them. A captured timestamp is read as two 32-bit words, upper word first. Reading the upper word freezes a copy of the lower word, so the pair always comes from one capture even if a new trigger edge arrives between the two reads. The trigger pins are asynchronous and pass through a synchronizer chain before edge detection.

Top module: `tsu_event_unit`

## Requirements
- R1: If trigger pin c is first sampled high at clock edge k, after being low, then after edge k+2 capture register c holds the time_i value that was present just before edge k+2.
- R2: A trigger held high captures once only. Each later low-to-high transition overwrites the capture register of that channel.
- R3: Status bit positions are: bit 0 for trigger 0, bit 1 for trigger 1, bit 2 for the alarm strobe and bit 3 for the pulse-per-second strobe. A trigger sets its bit at the same edge as its capture. A strobe high at an edge sets its bit at that edge.
- R4: A write to the status address (0) clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: When a status bit receives a set event and a clearing write in the same cycle, the bit ends up set.
- R6: irq_o is high exactly when some status bit and the same bit of the mask register (address 1, same bit positions) are both 1. A mask of zero holds irq_o low.
- R7: Reading the upper word of channel c (address 2+2c) with rd_en_i high copies the lower word of the stored capture into a shadow. A read of the lower word (address 3+2c) returns that shadow, unchanged by any capture that occurs after the upper-word read.
- R8: After reset the status, mask, capture registers and shadows read zero, and irq_o is low.
- R9: Addresses 0 and 1 read back status and mask in bits 3:0, with zero in the upper bits. Addresses 6 and 7 read zero. Writes to any address other than 0 and 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Current time value |
| trig_i | input | 2 | Asynchronous external trigger pins |
| alarm_stb_i | input | 1 | Single-cycle alarm event |
| pps_stb_i | input | 1 | Single-cycle pulse-per-second event |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write word address |
| wr_data_i | input | 4 | Write data (event bit vector) |
| rd_en_i | input | 1 | Register read strobe (needed for upper-word reads) |
| rd_addr_i | input | 3 | Read word address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the alarm and pulse-per-second strobes are synchronous to clk_i. They also assume that software reads the lower capture word in the cycle straight after the matching upper-word read, so the shadow check can compare against the lower word held one cycle earlier. The stimulus changes every input only at the falling clock edge and drives each strobe for exactly one cycle. Every lower-word read that the shadow property observes follows its upper-word read back to back. The trigger pins are deliberately held high for many cycles and toggled while reads are pending, to exercise the capture and shadow ordering.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
    // number of external trigger channels and of event sources
    localparam int unsigned N_EXT    = 2;
    localparam int unsigned N_EVT    = N_EXT + 2;
    // event bit positions (trigger channels occupy 0 .. N_EXT-1)
    localparam int unsigned EV_ALARM = N_EXT;
    localparam int unsigned EV_PPS   = N_EXT + 1;
    // word addresses
    localparam int unsigned ADR_STATUS   = 0;
    localparam int unsigned ADR_MASK     = 1;
    localparam int unsigned ADR_CAP_BASE = 2;
endpackage

// File: rtl/tsu_edge_sync.sv
module tsu_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_i};
        s_d.last  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o = s_q.chain[STAGES-1] & ~s_q.last;
endmodule

// File: rtl/tsu_capture.sv
module tsu_capture #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned TW    = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              take_i,
    input  logic [TW-1:0]     time_i,
    input  logic              hi_rd_i,
    output logic [TW-1:0]     stamp_o,
    output logic [DATA_W-1:0] lo_o
);
    typedef struct packed {
        logic [TW-1:0]     stamp;
        logic [DATA_W-1:0] shadow;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        // shadow takes the lower word of the capture that the upper read saw
        if (hi_rd_i) c_d.shadow = c_q.stamp[DATA_W-1:0];
        if (take_i)  c_d.stamp  = time_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    assign stamp_o = c_q.stamp;
    assign lo_o    = c_q.shadow;
endmodule

// File: rtl/tsu_event_ctrl.sv
module tsu_event_ctrl #(
    parameter int unsigned N_EVT = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] set_i,
    input  logic             st_wr_i,
    input  logic             mask_wr_i,
    input  logic [N_EVT-1:0] wdata_i,
    output logic [N_EVT-1:0] status_o,
    output logic [N_EVT-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_EVT-1:0] status;
        logic [N_EVT-1:0] mask;
    } evt_t;

    evt_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (st_wr_i)   e_d.status = e_q.status & ~wdata_i;
        // a new event wins over a clear in the same cycle
        e_d.status = e_d.status | set_i;
        if (mask_wr_i) e_d.mask = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) e_q <= '0;
        else         e_q <= e_d;
    end

    assign status_o = e_q.status;
    assign mask_o   = e_q.mask;
    assign irq_o    = |(e_q.status & e_q.mask);
endmodule

// File: rtl/tsu_event_unit.sv
module tsu_event_unit
    import tsu_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [2*DATA_W-1:0]   time_i,
    input  logic [N_EXT-1:0]      trig_i,
    input  logic                  alarm_stb_i,
    input  logic                  pps_stb_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [N_EVT-1:0]      wr_data_i,
    input  logic                  rd_en_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic                  irq_o
);
    localparam int unsigned TW = 2 * DATA_W;

    logic [N_EXT-1:0]             rise_w;
    logic [N_EXT-1:0][TW-1:0]     stamp_w;
    logic [N_EXT-1:0][DATA_W-1:0] lo_w;
    logic [N_EVT-1:0]             set_w;
    logic [N_EVT-1:0]             status_w;
    logic [N_EVT-1:0]             mask_w;
    logic                         st_wr_w;
    logic                         mask_wr_w;

    assign st_wr_w   = wr_en_i && (wr_addr_i == ADDR_W'(ADR_STATUS));
    assign mask_wr_w = wr_en_i && (wr_addr_i == ADDR_W'(ADR_MASK));

    generate
        for (genvar ch = 0; ch < N_EXT; ch++) begin : g_ch
            logic hi_rd;
            assign hi_rd = rd_en_i && (rd_addr_i == ADDR_W'(ADR_CAP_BASE + 2 * ch));

            tsu_edge_sync #(
                .STAGES (SYNC_STAGES)
            ) i_sync (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .pin_i  (trig_i[ch]),
                .rise_o (rise_w[ch])
            );

            tsu_capture #(
                .DATA_W (DATA_W)
            ) i_cap (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .take_i  (rise_w[ch]),
                .time_i  (time_i),
                .hi_rd_i (hi_rd),
                .stamp_o (stamp_w[ch]),
                .lo_o    (lo_w[ch])
            );
        end
    endgenerate

    always_comb begin
        set_w                   = '0;
        set_w[N_EXT-1:0]        = rise_w;
        set_w[EV_ALARM]         = alarm_stb_i;
        set_w[EV_PPS]           = pps_stb_i;
    end

    tsu_event_ctrl #(
        .N_EVT (N_EVT)
    ) i_evt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_i     (set_w),
        .st_wr_i   (st_wr_w),
        .mask_wr_i (mask_wr_w),
        .wdata_i   (wr_data_i),
        .status_o  (status_w),
        .mask_o    (mask_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_W'(ADR_STATUS)) rd_data_o = DATA_W'(status_w);
        if (rd_addr_i == ADDR_W'(ADR_MASK))   rd_data_o = DATA_W'(mask_w);
        for (int ch = 0; ch < N_EXT; ch++) begin
            if (rd_addr_i == ADDR_W'(ADR_CAP_BASE + 2 * ch))
                rd_data_o = stamp_w[ch][TW-1:DATA_W];
            if (rd_addr_i == ADDR_W'(ADR_CAP_BASE + 2 * ch + 1))
                rd_data_o = lo_w[ch];
        end
    end
endmodule

// File: rtl/tsu_event_unit_chk.sv
module tsu_event_unit_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned N_EVT  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              alarm_stb_i,
    input logic              pps_stb_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [N_EVT-1:0]  wr_data_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic [N_EVT-1:0]  status_w,
    input logic [N_EVT-1:0]  mask_w,
    input logic [DATA_W-1:0] stamp_lo_w
);
    logic              prev_hi_q;
    logic [DATA_W-1:0] prev_lo_q;
    logic              st_wr;

    assign st_wr = wr_en_i && (wr_addr_i == ADDR_W'(0));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_hi_q <= 1'b0;
            prev_lo_q <= '0;
        end else begin
            prev_hi_q <= rd_en_i && (rd_addr_i == ADDR_W'(2));
            prev_lo_q <= stamp_lo_w;
        end
    end

    // R6
    p_mask_zero_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_w == '0) |-> !irq_o);
    // R6
    p_irq_needs_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (status_w != '0));
    // R3
    p_alarm_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_stb_i |=> status_w[2]);
    // R5
    p_set_beats_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pps_stb_i && st_wr && wr_data_i[3]) |=> status_w[3]);
    // R4
    p_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_wr && wr_data_i[2] && !alarm_stb_i) |=> !status_w[2]);
    // R4
    p_status_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_wr && !alarm_stb_i) |=> $stable(status_w[2]));
    // R7
    p_coherent_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (prev_hi_q && rd_addr_i == ADDR_W'(3)) |-> (rd_data_o == prev_lo_q));
endmodule

bind tsu_event_unit tsu_event_unit_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_EVT  (tsu_pkg::N_EVT)
) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alarm_stb_i (alarm_stb_i),
    .pps_stb_i   (pps_stb_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_en_i     (rd_en_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .irq_o       (irq_o),
    .status_w    (status_w),
    .mask_w      (mask_w),
    .stamp_lo_w  (stamp_w[0][DATA_W-1:0])
);

// File: tb/test_tsu_event_unit.sv
module test_tsu_event_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] time_i;
    logic [1:0]  trig;
    logic        alarm_stb, pps_stb;
    logic        wr_en, rd_en;
    logic [2:0]  wr_addr, rd_addr;
    logic [3:0]  wr_data;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tsu_event_unit i_tsu_event_unit (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .time_i      (time_i),
        .trig_i      (trig),
        .alarm_stb_i (alarm_stb),
        .pps_stb_i   (pps_stb),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_en_i     (rd_en),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .irq_o       (irq)
    );

    // behavioural reference: trigger sample history, sticky flags, stored words
    logic [1:0]  hist [3];
    logic [3:0]  m_st, m_mask, setv;
    logic [63:0] m_cap [2];
    logic [31:0] m_sh  [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) hist[i] = 2'b00;
            m_st = 4'h0; m_mask = 4'h0;
            for (int c = 0; c < 2; c++) begin m_cap[c] = 64'h0; m_sh[c] = 32'h0; end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (rd_en && rd_addr == 3'(2 + 2 * c)) m_sh[c] = m_cap[c][31:0];
                if (hist[1][c] && !hist[2][c]) m_cap[c] = time_i;
            end
            setv = {pps_stb, alarm_stb, hist[1] & ~hist[2]};
            if (wr_en && wr_addr == 3'd0) m_st = m_st & ~wr_data;
            m_st = m_st | setv;
            if (wr_en && wr_addr == 3'd1) m_mask = wr_data;
            hist[2] = hist[1];
            hist[1] = hist[0];
            hist[0] = trig;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {28'h0, m_st};
            3'd1: return {28'h0, m_mask};
            3'd2: return m_cap[0][63:32];
            3'd3: return m_sh[0];
            3'd4: return m_cap[1][63:32];
            3'd5: return m_sh[1];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: sample at the falling edge, then advance the time input
    task automatic tick();
        @(negedge clk);
        chk("R6 irq level", 64'(irq), 64'(|(m_st & m_mask)));
        time_i = time_i + 64'd37;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        rd_en = 1'b1; rd_addr = a;
        #1;
        chk(tag, 64'(rd_data), 64'(exp_rd(a)));
        tick();
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [31:0] old_lo;

    initial begin
        rst_n = 1'b0; time_i = 64'hA5A5_0F0F_FFFF_FF00; trig = 2'b00;
        alarm_stb = 0; pps_stb = 0; wr_en = 0; rd_en = 0;
        wr_addr = 0; rd_addr = 0; wr_data = 0;
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R8: everything reads zero after reset
        for (int a = 0; a < 6; a++) rd(3'(a), "R8 reset value");
        chk("R8 irq low", 64'(irq), 64'h0);

        // R9: mask readback
        wr(3'd1, 4'hF);
        rd(3'd1, "R9 mask readback");

        // R1: capture on channel 0
        trig[0] = 1'b1;
        ticks(6);
        rd(3'd2, "R1 cap0 upper");
        rd(3'd3, "R1 cap0 lower");
        rd(3'd0, "R3 status trigger bit");

        // R2: held high, no second capture; new edge overwrites
        ticks(5);
        rd(3'd2, "R2 held upper");
        rd(3'd3, "R2 held lower");
        trig[0] = 1'b0; ticks(3);
        trig[0] = 1'b1; ticks(4);
        rd(3'd2, "R2 overwrite upper");
        rd(3'd3, "R2 overwrite lower");

        // R4: zero write keeps, one write clears
        wr(3'd0, 4'h0);
        rd(3'd0, "R4 zero write keeps");
        wr(3'd0, 4'h1);
        rd(3'd0, "R4 write one clears");
        chk("R4 bit0 cleared", 64'(rd_data[0]), 64'h0);

        // R3: strobes set bits 2 and 3
        alarm_stb = 1'b1; tick(); alarm_stb = 1'b0;
        rd(3'd0, "R3 alarm bit");
        pps_stb = 1'b1; tick(); pps_stb = 1'b0;
        rd(3'd0, "R3 pps bit");

        // R5: set and clear in one cycle
        alarm_stb = 1'b1;
        wr(3'd0, 4'h4);
        alarm_stb = 1'b0;
        rd(3'd0, "R5 set wins");
        wr(3'd0, 4'h8);
        rd(3'd0, "R4 pps cleared alone");

        // R6: masking
        wr(3'd1, 4'h0);
        chk("R6 mask zero", 64'(irq), 64'h0);
        wr(3'd1, 4'h2);
        chk("R6 unrelated bits masked", 64'(irq), 64'h0);
        trig[1] = 1'b1; ticks(4);
        chk("R6 channel 1 raises irq", 64'(irq), 64'h1);

        // R7: upper read freezes lower word across a new capture
        trig[1] = 1'b0; ticks(3);
        old_lo = m_cap[1][31:0];
        rd(3'd4, "R7 upper first");
        trig[1] = 1'b1; ticks(5);
        rd(3'd5, "R7 lower from same capture");
        chk("R7 lower equals frozen", 64'(rd_data), 64'(old_lo));
        rd(3'd4, "R7 new upper");
        rd(3'd5, "R7 new lower");

        // R9: unmapped addresses and read-only words
        rd(3'd6, "R9 unmapped 6");
        rd(3'd7, "R9 unmapped 7");
        wr(3'd2, 4'hF);
        rd(3'd2, "R9 capture not writable");
        wr(3'd6, 4'hF);
        rd(3'd0, "R9 stray write status");
        rd(3'd1, "R9 stray write mask");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule